// File: doc/BRIEF.md
# Dual-channel prescaled PWM controller

This block generates one pulse-width-modulated output per channel (two channels by default) from a single source clock. Software programs it through a small synchronous register bus. One control word holds a packed field group per channel. Each channel also has its own period/duty word. A channel divides the source clock by a factor picked from a fixed table of codes. It then counts prescaled ticks over a programmable period and drives its output to the active level for the first "duty" ticks of each period. The active level is selectable.

A new period/duty value is held in a shadow register and taken at the next period boundary, so a running waveform never shows a torn period. A per-channel ready flag in the control word tells software when the value has been taken. A bypass control routes the source clock straight to the output. This gives a 50% square wave at the full clock rate, whatever the other settings are.

Top module: `pwm_dual_ctrl`

## Requirements
- R1: Register map (byte addresses). The control word is at 0x0. Channel n's field group is at bit 15*n: [3:0] prescaler code, bit 4 enable, bit 5 active-level select, bit 6 clock run, bit 7 and bit 8 spare storage, bit 9 bypass. Channel n's ready flag reads at bit 28+n. All other bits read 0, and writes to them are dropped. Channel n's period/duty word is at 0x4+4*n and reads back the value last written to it. Reset clears every stored bit.
- R2: Prescaler codes 0..4 divide the source clock by 120, 180, 240, 360 and 480. Codes 8..12 divide by 12000, 24000, 36000, 48000 and 72000. Code 15 divides by 1.
- R3: In the period/duty word, bits [31:16] hold the period in prescaled ticks minus one, and bits [15:0] hold the duty in ticks. A running channel is in its active phase for ticks 0..duty-1 of each period. The waveform starts with tick 0 on the cycle after the write that starts the channel.
- R4: A channel runs only while its enable and clock-run bits are both 1. Otherwise its prescaler and tick counter are held at zero and its output sits at the inactive level. A channel that is restarted begins again at tick 0.
- R5: With the active-level select at 1, the output is high in the active phase. With it at 0, the output is inverted, so the inactive level is high. After reset both outputs are high.
- R6: Prescaler codes 5, 6, 7, 13 and 14 are invalid. They stop the channel and hold its output at the inactive level.
- R7: While bypass is 1, the channel output equals the source clock, whatever the enable, clock-run, code and active-level settings are.
- R8: A write to a running channel's period/duty word takes effect only at the end of the current period. That channel's ready flag reads 0 from the cycle after the write until the update is taken, and reads 1 once it has been taken.
- R9: A duty greater than the period tick count keeps a running output at its active level for the whole period. A duty of 0 keeps it at its inactive level.
- R10: A channel that is not running takes a pending period/duty update on the next clock, so its ready flag returns to 1 one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; also the bypass output source |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | NCH (2) | One PWM output per channel |

## Verification
The embedded assertions watch the internal invariants on every cycle. They check that the tick counter never passes the active period, that the prescaler stays below its divide factor, that an idle channel's counter is cleared, that a write drops the ready flag, and that the ready flag only rises at a period end or while the channel is idle. The bench scenarios are needed to show the waveform itself against the stated codes, polarity and duty corner cases. They also show the exact cycle on which a shadowed update lands, the ignored-settings behaviour of bypass and invalid codes, and the register readback layout.

// File: rtl/pwm_dual_pkg.sv
// Shared definitions for the dual-channel PWM controller.
// Holds the per-channel control field layout and the prescaler code decode.
// Assumes at most two channels, so the ready flags at bit 28 never collide
// with the 15-bit channel stride.
package pwm_dual_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CH_STRIDE  = 15;  // bit distance between channel field groups
    localparam int CH_FIELD_W = 10;  // stored bits per channel group
    localparam int READY_BASE = 28;  // bit of channel 0 ready flag
    localparam int PRE_W      = 17;  // wide enough for the largest divide factor

    // Per-channel control fields, MSB first so bit positions match the word.
    typedef struct packed {
        logic       bypass;  // bit 9
        logic       spare1;  // bit 8
        logic       spare0;  // bit 7
        logic       run;     // bit 6, clock run
        logic       act;     // bit 5, active level select
        logic       en;      // bit 4
        logic [3:0] code;    // bits 3:0
    } chan_ctrl_t;

    // Divide factor for a prescaler code; zero marks an invalid code.
    function automatic logic [PRE_W-1:0] prescale_div(input logic [3:0] code);
        logic [PRE_W-1:0] f;
        case (code)
            4'd0:    f = PRE_W'(120);
            4'd1:    f = PRE_W'(180);
            4'd2:    f = PRE_W'(240);
            4'd3:    f = PRE_W'(360);
            4'd4:    f = PRE_W'(480);
            4'd8:    f = PRE_W'(12000);
            4'd9:    f = PRE_W'(24000);
            4'd10:   f = PRE_W'(36000);
            4'd11:   f = PRE_W'(48000);
            4'd12:   f = PRE_W'(72000);
            4'd15:   f = PRE_W'(1);
            default: f = '0;
        endcase
        return f;
    endfunction
endpackage

// File: rtl/pwm_prescaler.sv
// Clock prescaler for one PWM channel.
// Emits a one-cycle tick every div source cycles while run is high.
// Assumes div is nonzero whenever run is high; held at zero while idle.
module pwm_prescaler
    import pwm_dual_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] div,
    output logic          tick
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [PW-1:0] pre_q;
    logic [PW-1:0] last;

    assign last = div - PW'(1);
    // The >= also covers a divide factor lowered while counting.
    assign tick = run && (pre_q >= last);

    // Count source cycles within one prescaled tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end

    // R2
    pre_lt_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $stable(div) && ($past(pre_q) < $past(div))) |-> (pre_q < div));
endmodule

// File: rtl/pwm_period_counter.sv
// Period/duty tick counter with a shadowed period/duty register.
// Writes land in the shadow; the live pair is loaded at a period end or
// while the channel is idle. Phase is high for ticks below the duty.
// Assumes tick is only asserted while run is high.
module pwm_period_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [2*CW-1:0] wr_data,
    output logic [2*CW-1:0] shadow_o,
    output logic          ready_o,
    output logic          phase_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [2*CW-1:0] shadow_q;
    logic            pending_q;
    logic [CW-1:0]   prd_q;
    logic [CW-1:0]   dty_q;
    logic [CW-1:0]   cnt_q;
    logic            wrap;
    logic            take;

    assign wrap = tick && (cnt_q == prd_q);
    assign take = pending_q && (!run || wrap);

    // Hold software's last write and flag it until taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q  <= '0;
            pending_q <= 1'b0;
        end else if (wr_en) begin
            shadow_q  <= wr_data;
            pending_q <= 1'b1;
        end else if (take) begin
            pending_q <= 1'b0;
        end
    end

    // Load the live period/duty pair from the shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_q <= '0;
            dty_q <= '0;
        end else if (take) begin
            prd_q <= shadow_q[2*CW-1:CW];
            dty_q <= shadow_q[CW-1:0];
        end
    end

    // Step the tick counter through one period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || wrap) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign shadow_o = shadow_q;
    assign ready_o  = !pending_q;
    assign phase_o  = run && (cnt_q < dty_q);

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= prd_q));
    // R4
    idle_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
    // R8
    wr_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !ready_o);
    // R8
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(!run || wrap));
endmodule

// File: rtl/pwm_channel.sv
// One PWM channel: prescaler, period counter, polarity and bypass select.
// Assumes the control fields come straight from the shared control word.
// In bypass the output is the source clock itself.
module pwm_channel
    import pwm_dual_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      code,
    input  logic            en,
    input  logic            act,
    input  logic            run_bit,
    input  logic            bypass,
    input  logic            wr_en,
    input  logic [2*CW-1:0] wr_data,
    output logic [2*CW-1:0] shadow_o,
    output logic            ready_o,
    output logic            pwm_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [PRE_W-1:0] div;
    logic             valid;
    logic             run;
    logic             tick;
    logic             phase;

    assign div   = prescale_div(code);
    assign valid = (div != '0);
    assign run   = en && run_bit && valid && !bypass;

    pwm_prescaler #(.PW(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div),
        .tick  (tick)
    );

    pwm_period_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .shadow_o (shadow_o),
        .ready_o  (ready_o),
        .phase_o  (phase)
    );

    // Select bypass clock or the polarity-adjusted phase.
    always_comb begin
        if (bypass) begin
            pwm_o = clk;
        end else begin
            pwm_o = act ? phase : !phase;
        end
    end
endmodule

// File: rtl/pwm_dual_ctrl.sv
// Register-programmed PWM controller, top level.
// Decodes the bus, stores the shared control word, and replicates one
// channel per output. Assumes NCH <= 2 and a 32-bit data bus.
module pwm_dual_ctrl
    import pwm_dual_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CW     = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DW = 2 * CW;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

    chan_ctrl_t       ctrl_q  [NCH];
    logic [DW-1:0]    shadow  [NCH];
    logic [NCH-1:0]   ready;
    logic             ctrl_sel;

    assign ctrl_sel = (bus_addr == CTRL_ADDR);

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam logic [ADDR_W-1:0] PD_ADDR = ADDR_W'(4 + 4 * n);
        logic pd_we;

        assign pd_we = bus_we && (bus_addr == PD_ADDR);

        // Store this channel's field group from a control-word write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q[n] <= '0;
            end else if (bus_we && ctrl_sel) begin
                ctrl_q[n] <= chan_ctrl_t'(bus_wdata[CH_STRIDE*n +: CH_FIELD_W]);
            end
        end

        pwm_channel #(.CW(CW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .code     (ctrl_q[n].code),
            .en       (ctrl_q[n].en),
            .act      (ctrl_q[n].act),
            .run_bit  (ctrl_q[n].run),
            .bypass   (ctrl_q[n].bypass),
            .wr_en    (pd_we),
            .wr_data  (bus_wdata[DW-1:0]),
            .shadow_o (shadow[n]),
            .ready_o  (ready[n]),
            .pwm_o    (pwm_out[n])
        );
    end

    // Assemble read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (ctrl_sel) begin
            for (int n = 0; n < NCH; n++) begin
                bus_rdata[CH_STRIDE*n +: CH_FIELD_W] = ctrl_q[n];
                bus_rdata[READY_BASE + n]            = ready[n];
            end
        end else begin
            for (int n = 0; n < NCH; n++) begin
                if (bus_addr == ADDR_W'(4 + 4 * n)) begin
                    bus_rdata[DW-1:0] = shadow[n];
                end
            end
        end
    end
endmodule

// File: tb/pwm_dual_ctrl_bench.sv
// Self-checking bench: directed corner cases plus seeded random waveforms.
module pwm_dual_ctrl_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwm_out;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] ctrl_sh = '0;

    always #2.5 clk = ~clk;

    pwm_dual_ctrl u_pwm_dual_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

    task automatic check_eq(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, got, exp);
        end
    endtask

    // Divide factor per code, taken from the requirement text.
    function automatic int exp_div(input int code);
        case (code)
            0: return 120;   1: return 180;   2: return 240;   3: return 360;   4: return 480;
            8: return 12000; 9: return 24000; 10: return 36000; 11: return 48000; 12: return 72000;
            15: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic exp_level(input int k, input int n, input int p, input int d, input logic act);
        int  t;
        logic a;
        t = (k / n) % p;
        a = (t < d);
        return act ? a : !a;
    endfunction

    // Called at a negedge; write lands on the next posedge, returns at the following negedge.
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [9:0] fields(input int code, input bit en, input bit run, input bit act, input bit byp);
        return {byp, 2'b00, run, act, en, code[3:0]};
    endfunction

    // Stop channel, load period/duty, then start; returns at tick 0.
    task automatic start_chan(input int ch, input int code, input int pf, input int duty, input bit act);
        logic [31:0] r;
        ctrl_sh[15*ch +: 10] = fields(0, 0, 0, act, 0);
        bus_write(4'd0, ctrl_sh);
        bus_write(4'(4 + 4 * ch), {pf[15:0], duty[15:0]});
        @(negedge clk);
        bus_read(4'd0, r);
        check_eq("R10 idle take", 32'(r[28 + ch]), 32'd1);
        ctrl_sh[15*ch +: 10] = fields(code, 1, 1, act, 0);
        bus_write(4'd0, ctrl_sh);
    endtask

    task automatic sample_chan(input string req, input int ch, input int code, input int pf,
                               input int duty, input bit act, input int nsamp);
        for (int k = 0; k < nsamp; k++) begin
            check_eq(req, 32'(pwm_out[ch]), 32'(exp_level(k, exp_div(code), pf + 1, duty, act)));
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R5 R8: reset state
        bus_read(4'd0, r);
        check_eq("R1 reset ctrl", r, 32'h3000_0000);
        bus_read(4'd4, r);
        check_eq("R1 reset pd0", r, 32'h0);
        check_eq("R5 reset outputs", 32'(pwm_out), 32'h3);

        // R1: field layout, dropped bits, period/duty readback
        bus_write(4'd0, 32'h4040_7D80);
        bus_read(4'd0, r);
        check_eq("R1 ctrl readback", r, 32'h3040_0180);
        bus_write(4'd8, 32'hABCD_1234);
        bus_read(4'd8, r);
        check_eq("R1 pd1 readback", r, 32'hABCD_1234);
        ctrl_sh = '0;
        bus_write(4'd0, ctrl_sh);

        // R3 R2: basic divide-by-one waveforms
        start_chan(0, 15, 4, 2, 1);
        sample_chan("R3 code15", 0, 15, 4, 2, 1, 12);
        // R5: inverted polarity
        start_chan(1, 15, 3, 1, 0);
        sample_chan("R5 inverted", 1, 15, 3, 1, 0, 10);
        // R9: duty beyond period, and zero duty
        start_chan(0, 15, 2, 7, 1);
        sample_chan("R9 full duty", 0, 15, 2, 7, 1, 8);
        start_chan(0, 15, 2, 0, 1);
        sample_chan("R9 zero duty", 0, 15, 2, 0, 1, 8);
        // R2: large divider from the upper code group
        start_chan(1, 8, 1, 1, 1);
        sample_chan("R2 code8", 1, 8, 1, 1, 1, 24002);

        // R8: shadowed update lands at the period end
        start_chan(0, 15, 3, 1, 1);
        check_eq("R8 k0 out", 32'(pwm_out[0]), 32'd1);
        bus_write(4'd4, {16'd1, 16'd2});
        check_eq("R8 k1 out old", 32'(pwm_out[0]), 32'd0);
        bus_read(4'd0, r);
        check_eq("R8 k1 ready low", 32'(r[28]), 32'd0);
        @(negedge clk); @(negedge clk);
        check_eq("R8 k3 out old", 32'(pwm_out[0]), 32'd0);
        bus_read(4'd0, r);
        check_eq("R8 k3 ready low", 32'(r[28]), 32'd0);
        @(negedge clk);
        bus_read(4'd0, r);
        check_eq("R8 k4 ready high", 32'(r[28]), 32'd1);
        for (int k = 4; k < 8; k++) begin
            check_eq("R8 new duty", 32'(pwm_out[0]), 32'd1);
            @(negedge clk);
        end

        // R4: stop by clock-run clear, then restart at tick 0
        start_chan(0, 15, 5, 3, 1);
        repeat (4) @(negedge clk);
        check_eq("R4 k4 out", 32'(pwm_out[0]), 32'd0);
        ctrl_sh[9:0] = fields(15, 1, 0, 1, 0);
        bus_write(4'd0, ctrl_sh);
        for (int k = 0; k < 3; k++) begin
            check_eq("R4 stopped", 32'(pwm_out[0]), 32'd0);
            @(negedge clk);
        end
        ctrl_sh[9:0] = fields(15, 1, 1, 1, 0);
        bus_write(4'd0, ctrl_sh);
        sample_chan("R4 restart", 0, 15, 5, 3, 1, 8);
        ctrl_sh[9:0] = fields(15, 0, 1, 0, 0);
        bus_write(4'd0, ctrl_sh);
        check_eq("R4 enable off", 32'(pwm_out[0]), 32'd1);

        // R6: invalid codes hold the inactive level
        start_chan(0, 6, 3, 2, 1);
        for (int k = 0; k < 10; k++) begin
            check_eq("R6 code6", 32'(pwm_out[0]), 32'd0);
            @(negedge clk);
        end
        start_chan(1, 13, 3, 2, 0);
        for (int k = 0; k < 10; k++) begin
            check_eq("R6 code13", 32'(pwm_out[1]), 32'd1);
            @(negedge clk);
        end

        // R7: bypass follows the clock with enable clear
        ctrl_sh[9:0] = fields(5, 0, 0, 0, 1);
        bus_write(4'd0, ctrl_sh);
        for (int k = 0; k < 3; k++) begin
            check_eq("R7 bypass low", 32'(pwm_out[0]), 32'd0);
            @(posedge clk);
            #1;
            check_eq("R7 bypass high", 32'(pwm_out[0]), 32'd1);
            @(negedge clk);
        end
        ctrl_sh = '0;
        bus_write(4'd0, ctrl_sh);

        // R3 R2 R5: seeded random waveforms
        for (int i = 0; i < 14; i++) begin
            int ch, code, pf, duty, sel, nsamp;
            bit act;
            ch  = int'($urandom % 2);
            sel = int'($urandom % 5);
            code = (sel < 2) ? 15 : ((sel == 2) ? 0 : ((sel == 3) ? 2 : 4));
            pf   = (code == 15) ? int'($urandom % 10) : int'($urandom % 3);
            duty = int'($urandom % (pf + 3));
            act  = 1'($urandom % 2);
            nsamp = exp_div(code) * (pf + 1) * 2;
            start_chan(ch, code, pf, duty, act);
            sample_chan("R3 random", ch, code, pf, duty, act, nsamp);
        end

        summary();
        $finish;
    end
endmodule